// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block sits in the feedback path of an integer-N frequency synthesizer. It divides its input clock by N = B·P + A and emits a one-cycle pulse towards the phase comparator once per N input cycles. It does this by steering a dual-modulus prescaler stage between P+1 and P. A 5-bit swallow count A sets how many prescaler periods run at P+1. A 12-bit main count B sets how many prescaler periods make up one output period. The base modulus P is 16 or 19, chosen by a select input.

Software programs A, B and the modulus select as plain inputs. The divider samples them only at the end of an output period, so each period is built from a single ratio. A setting whose main count is not strictly greater than its swallow count cannot give the intended N. Such a setting is refused at the boundary: an error flag rises and the previous ratio stays in force. After reset the divider runs a built-in legal ratio of 256 (A=0, B=16, P=16) until its first boundary.

Top module: `dm_feedback_div`

## Requirements
- R1: `fb_pulse_o` is high for exactly one clock cycle per output period, and pulses are spaced exactly N = B·P + A clock cycles apart, with A, B and P taken from the active setting.
- R2: The base modulus is P = 16 when the active select bit is 0 and P = 19 when it is 1, so the prescaler stage divides by 16/17 or 19/20.
- R3: Within each output period, `mod_hi_o` (1 = prescaler divides by P+1) is high for the first A·(P+1) clock cycles and low for the remaining (B−A)·P cycles. It is therefore low in the cycle that carries the output pulse.
- R4: A covers 0 to 31 and B covers up to 4095, so the extreme ratios 256 (A=0, B=16, P=16), 361 (A=0, B=19, P=19) and 77836 (A=31, B=4095, P=19) are produced exactly.
- R5: `swal_i`, `main_i` and `psel_i` are sampled only on the clock edge that ends an output period (the edge right after the cycle in which `fb_pulse_o` is high). Changing them at any other time has no effect on the period in progress.
- R6: If `main_i` ≤ `swal_i` at a period boundary, `cfg_err_o` is 1 from that edge on, and the next period keeps the previous active ratio.
- R7: A legal setting (`main_i` > `swal_i`) sampled at a boundary clears `cfg_err_o` and becomes the active ratio for the next period.
- R8: While `rst_n` is low, `fb_pulse_o`, `mod_hi_o` and `cfg_err_o` are 0. The first period after reset lasts 256 cycles, with `mod_hi_o` low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock (prescaler input) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| swal_i | input | 5 | Swallow count A for the next period |
| main_i | input | 12 | Main count B for the next period |
| psel_i | input | 1 | Modulus select for the next period: 0 gives P=16, 1 gives P=19 |
| fb_pulse_o | output | 1 | One-cycle pulse per N input cycles, towards the phase comparator |
| mod_hi_o | output | 1 | Prescaler modulus control: 1 selects P+1, 0 selects P |
| cfg_err_o | output | 1 | Last sampled setting was refused because B ≤ A |

## Verification
The bench sweeps every swallow count 0 to 31 with the tightest legal main count B = A+1, under both moduli. Each of these periods separates an off-by-one in the swallow or main count from a wrong modulus, because every A gives a different length. Counting the cycles with `mod_hi_o` high in each period shows whether the swallow phase ends after exactly A prescaler periods, not merely whether the total length comes out right. The extreme ratios test the full width of the main count. A run of refused settings, including B = A and B = 0, checks that the previous ratio is held. A period in which the inputs are driven to an illegal pattern mid-way and then restored shows that only boundary samples matter.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  parameter int SWAL_W = 5;
  parameter int MAIN_W = 12;

  typedef struct packed {
    logic [SWAL_W-1:0] swal;
    logic [MAIN_W-1:0] main;
    logic              psel;
  } fdiv_cfg_t;

endpackage

// File: rtl/fdiv_cfg_gate.sv
module fdiv_cfg_gate
  import fdiv_pkg::*;
#(
  parameter int RST_SWAL = 0,
  parameter int RST_MAIN = 16,
  parameter bit RST_PSEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SWAL_W-1:0] swal_in,
  input  logic [MAIN_W-1:0] main_in,
  input  logic              psel_in,
  output fdiv_cfg_t         act_cfg,
  output fdiv_cfg_t         nxt_cfg,
  output logic              err
);

  localparam fdiv_cfg_t RST_CFG = '{swal: SWAL_W'(RST_SWAL),
                                    main: MAIN_W'(RST_MAIN),
                                    psel: RST_PSEL};

  fdiv_cfg_t act_q, act_d;
  logic      err_q, err_d;
  logic      legal;

  always_comb begin
    legal = (main_in > MAIN_W'(swal_in));
    act_d = act_q;
    err_d = err_q;
    if (load) begin
      err_d = ~legal;
      if (legal) begin
        act_d.swal = swal_in;
        act_d.main = main_in;
        act_d.psel = psel_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= RST_CFG;
      err_q <= 1'b0;
    end else if (load) begin
      act_q <= act_d;
      err_q <= err_d;
    end
  end

  assign act_cfg = act_q;
  assign nxt_cfg = act_d;
  assign err     = err_q;

endmodule

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
  parameter int P_LO = 16,
  parameter int P_HI = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic psel,
  input  logic mod_hi,
  output logic tick
);

  localparam int            PC_W  = $clog2(P_HI + 2);
  localparam logic [PC_W-1:0] LO_M1 = PC_W'(P_LO - 1);
  localparam logic [PC_W-1:0] HI_M1 = PC_W'(P_HI - 1);

  logic [PC_W-1:0] cnt_q, cnt_d;
  logic [PC_W-1:0] last;

  always_comb begin
    last  = (psel ? HI_M1 : LO_M1) + {{(PC_W-1){1'b0}}, mod_hi};
    tick  = (cnt_q == last);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fdiv_swallow.sv
module fdiv_swallow
  import fdiv_pkg::*;
#(
  parameter int RST_SWAL = 0,
  parameter int RST_MAIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [SWAL_W-1:0] reload_swal,
  input  logic [MAIN_W-1:0] reload_main,
  output logic              mod_hi,
  output logic              frame_end
);

  logic [SWAL_W-1:0] a_q, a_d;
  logic [MAIN_W-1:0] b_q, b_d;
  logic              cnt_en;

  always_comb begin
    mod_hi    = (a_q != '0);
    frame_end = tick && (b_q == MAIN_W'(1));
    cnt_en    = tick;
    a_d       = a_q;
    b_d       = b_q;
    if (frame_end) begin
      a_d = reload_swal;
      b_d = reload_main;
    end else begin
      b_d = b_q - 1'b1;
      if (mod_hi) a_d = a_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= SWAL_W'(RST_SWAL);
      b_q <= MAIN_W'(RST_MAIN);
    end else if (cnt_en) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

endmodule

// File: rtl/dm_feedback_div.sv
module dm_feedback_div
  import fdiv_pkg::*;
#(
  parameter int P_LO     = 16,
  parameter int P_HI     = 19,
  parameter int RST_SWAL = 0,
  parameter int RST_MAIN = 16,
  parameter bit RST_PSEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SWAL_W-1:0] swal_i,
  input  logic [MAIN_W-1:0] main_i,
  input  logic              psel_i,
  output logic              fb_pulse_o,
  output logic              mod_hi_o,
  output logic              cfg_err_o
);

  fdiv_cfg_t         act_cfg, nxt_cfg;
  logic              pre_tick;
  logic              frame_end;
  logic              mod_hi;
  logic [SWAL_W-1:0] act_swal;
  logic [MAIN_W-1:0] act_main;

  fdiv_cfg_gate #(
    .RST_SWAL(RST_SWAL), .RST_MAIN(RST_MAIN), .RST_PSEL(RST_PSEL)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(frame_end),
    .swal_in(swal_i), .main_in(main_i), .psel_in(psel_i),
    .act_cfg(act_cfg), .nxt_cfg(nxt_cfg), .err(cfg_err_o)
  );

  fdiv_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
    .clk(clk), .rst_n(rst_n), .psel(act_cfg.psel),
    .mod_hi(mod_hi), .tick(pre_tick)
  );

  fdiv_swallow #(.RST_SWAL(RST_SWAL), .RST_MAIN(RST_MAIN)) u_swl (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick),
    .reload_swal(nxt_cfg.swal), .reload_main(nxt_cfg.main),
    .mod_hi(mod_hi), .frame_end(frame_end)
  );

  assign act_swal   = act_cfg.swal;
  assign act_main   = act_cfg.main;
  assign fb_pulse_o = frame_end;
  assign mod_hi_o   = mod_hi;

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker
  import fdiv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fb_pulse,
  input logic              mod_hi,
  input logic              cfg_err,
  input logic              pre_tick,
  input logic [SWAL_W-1:0] act_a,
  input logic [MAIN_W-1:0] act_b,
  input logic [SWAL_W-1:0] in_a,
  input logic [MAIN_W-1:0] in_b
);

  p_pulse_narrow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  p_pulse_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> pre_tick);

  p_mod_moves_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_hi) |-> $past(pre_tick));

  p_mod_low_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> !mod_hi);

  p_load_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_a) || !$stable(act_b)) |-> $past(fb_pulse));

  p_active_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_b > MAIN_W'(act_a));

  p_hold_on_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && (in_b <= MAIN_W'(in_a))) |=>
      (act_a == $past(act_a) && act_b == $past(act_b) && cfg_err));

  p_err_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_err) |-> $past(fb_pulse));

endmodule

bind dm_feedback_div fdiv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fb_pulse(fb_pulse_o), .mod_hi(mod_hi_o),
  .cfg_err(cfg_err_o), .pre_tick(pre_tick), .act_a(act_swal),
  .act_b(act_main), .in_a(swal_i), .in_b(main_i)
);

// File: tb/dm_feedback_div_bench.sv
module dm_feedback_div_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  swal;
  logic [11:0] main;
  logic        psel;
  logic        fb_pulse, mod_hi, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int cur_a, cur_b, cur_s;
  bit exp_err;

  always #4 clk = ~clk;

  dm_feedback_div u_dm_feedback_div (
    .clk(clk), .rst_n(rst_n), .swal_i(swal), .main_i(main), .psel_i(psel),
    .fb_pulse_o(fb_pulse), .mod_hi_o(mod_hi), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pval(input int s);
    return (s != 0) ? 19 : 16;
  endfunction

  // Called at a negedge just after a load edge (or at reset release).
  // Presents the next setting, measures the period now running, then
  // checks the error flag produced by the boundary that ends it.
  task automatic step(input int a, input int b, input int s, input bit junk,
                      input string tag);
    int exp_n, exp_m, c, m;
    swal  = 5'(a); main = 12'(b); psel = s[0];
    exp_n = cur_b * pval(cur_s) + cur_a;
    exp_m = cur_a * (pval(cur_s) + 1);
    c = 0; m = 0;
    forever begin
      if (mod_hi) m++;
      if (fb_pulse) break;
      @(negedge clk);
      c++;
      if (junk && c == 5) begin
        swal = 5'd31; main = 12'd3; psel = ~s[0];
      end
      if (junk && c == exp_n - 10) begin
        swal = 5'(a); main = 12'(b); psel = s[0];
      end
    end
    @(negedge clk);
    chk((c + 1) == exp_n, {tag, " R1 R2"}, "period", c + 1, exp_n);
    chk(m == exp_m, {tag, " R3"}, "cycles at P+1", m, exp_m);
    if (b > a) begin
      cur_a = a; cur_b = b; cur_s = s; exp_err = 1'b0;
    end else begin
      exp_err = 1'b1;
    end
    chk(cfg_err == exp_err, exp_err ? "R6" : "R7", "error flag",
        int'(cfg_err), int'(exp_err));
  endtask

  initial begin
    rst_n = 1'b0; swal = '0; main = '0; psel = 1'b0;
    cur_a = 0; cur_b = 16; cur_s = 0; exp_err = 1'b0;
    repeat (3) @(negedge clk);
    chk(!fb_pulse && !mod_hi && !cfg_err, "R8", "outputs in reset",
        {29'd0, fb_pulse, mod_hi, cfg_err}, 0);
    rst_n = 1'b1;
    // first step measures the default 256 period (R8)
    step(0, 1, 0, 1'b0, "R8");
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 32; a++) begin
        step(a, a + 1, s, 1'b0, "sweep");
      end
    end
    step(31, 4095, 1, 1'b0, "R4");
    step(0, 19, 1, 1'b0, "R4 max");
    step(0, 16, 0, 1'b0, "R4 min19");
    step(5, 5, 0, 1'b0, "R4 min16");
    step(9, 3, 1, 1'b0, "R6 hold");
    step(0, 0, 0, 1'b0, "R6 hold");
    step(7, 40, 1, 1'b0, "R6 hold");
    step(3, 20, 0, 1'b1, "R5 junk");
    step(3, 20, 0, 1'b1, "R5 junk");
    step(3, 20, 0, 1'b0, "R7");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule